// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block chooses divider settings for a display clock synthesiser. Given a requested pixel clock in kHz, the reference clock in kHz, a flag saying whether the pipe drives a flat panel and a flag that selects the newer or older chip generation, it walks every candidate combination of the feedback dividers (m1, m2), the input divider (n) and the first post divider (p1). The second post divider p2 is fixed from the request before the walk begins. Each candidate first goes through range checks that need no division. A survivor then has its VCO frequency and output frequency worked out with sequential restoring dividers. The legal candidate whose output clock lies closest to the request is kept.

A search starts with a one-cycle `start_i`. All request inputs are captured at that moment. `busy_o` stays high while the walk runs, and a single-cycle `done_o` marks the end. The found flag, the chosen dividers, the packed feedback/input divider word and the one-hot p1 field then hold their values until the next search begins. Candidates are handled one at a time. The VCO quotient for one (m1, m2, n) triple is reused for all eight p1 values.

Top module: `pll_div_search`

## Requirements
- R1: The VCO is floor(ref × M / (n+2)) with M = 5·(m1+2) + (m2+2). The output clock is floor(VCO / (p1·p2)), and the error is |output − target|.
- R2: Newer generation allows m1 10..20, m2 5..9, M 70..120 and n+2 3..8. Older generation allows m1 16..24, m2 7..11, M 90..130 and n+2 4..8.
- R3: p1+p2 must lie in 5..80. On the newer generation with a panel it must lie in 7..98 instead. On the older generation with a panel, the lower limits for n+2 and M become 3 and 88.
- R4: A candidate is rejected if m1 ≤ m2, if p1 is outside 1..8, if the VCO is outside 1,400,000..2,800,000, or if the output clock is outside 20,000..400,000.
- R5: p2 is set from the request. With a panel it is 14 when the target is below 200,000 and 7 otherwise. Without a panel it is 10 when the target is below 200,000 and 5 otherwise.
- R6: The sweep has four nested levels. m1 is the outermost and runs from its minimum to its maximum inclusive. m2 runs from its minimum up to one below its maximum. n runs from 1 to 6. p1 is the innermost and runs from 1 to 8. The kept result is the first candidate in this order with the smallest error.
- R7: The best error starts equal to the target and is replaced only by a strictly smaller one. `found_o` is 1 exactly when the final best error differs from the target. When nothing is found, m1, m2, n, p1, the packed word and the p1 field all read zero, and p2 still shows the chosen value.
- R8: The packed word holds n in bits 23:16, m1 in bits 15:8 and m2 in bits 7:0. The p1 field is one-hot with bit (p1−1) set; this field occupies bits 23:16 of a PLL control word.
- R9: `busy_o` rises in the cycle after `start_i` and falls when `done_o` pulses for one cycle. A `start_i` that arrives while busy is ignored, and inputs are captured only when the search starts. While idle, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (taken only when idle) |
| target_i | input | TGT_W | Requested pixel clock in kHz |
| refclk_i | input | REF_W | Reference clock in kHz |
| panel_i | input | 1 | Pipe drives a flat panel |
| newgen_i | input | 1 | 1 = newer generation ranges, 0 = older |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | A legal improving candidate was found |
| m1_o | output | FLD_W | Chosen m1 |
| m2_o | output | FLD_W | Chosen m2 |
| n_o | output | FLD_W | Chosen n |
| p1_o | output | 4 | Chosen p1 |
| p2_o | output | 4 | Fixed p2 of this search |
| fp_word_o | output | 3*FLD_W | Packed {n, m1, m2} |
| p1_field_o | output | 8 | One-hot p1 field |

## Verification
Each search is compared field by field with a behavioural model of the nested sweep. The bench runs four patterns. A non-panel request below the split on the newer generation exercises p2 = 10 and the main ranges. A panel request below the split on the older generation exercises p2 = 14 and the relaxed n+2 and M minimums. A panel request above the split on the newer generation exercises p2 = 7 and the wider post-divide window. A request whose reference is so low that no VCO can reach its window must end with nothing found and p2 = 5. In one search, a second start with altered inputs is issued during the sweep; the result must still match the first request.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int VCO_LO   = 1400000;
  localparam int VCO_HI   = 2800000;
  localparam int DOT_LO   = 20000;
  localparam int DOT_HI   = 400000;
  localparam int P2_SPLIT = 200000;
  localparam int N_FIRST  = 1;
  localparam int N_LAST   = 6;
  localparam int P1_LAST  = 8;

  typedef struct packed {
    logic [7:0] m1_lo;
    logic [7:0] m1_hi;
    logic [7:0] m2_lo;
    logic [7:0] m2_hi;
    logic [7:0] mt_lo;
    logic [7:0] mt_hi;
    logic [3:0] nt_lo;
    logic [3:0] nt_hi;
    logic [6:0] pt_lo;
    logic [6:0] pt_hi;
  } lim_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TRIP, ST_VDIV, ST_PCHK, ST_DDIV, ST_FIN
  } st_t;

  function automatic logic [3:0] pick_p2(input logic panel, input logic low);
    if (panel) return low ? 4'd14 : 4'd7;
    return low ? 4'd10 : 4'd5;
  endfunction

endpackage

// File: rtl/pll_range_sel.sv
module pll_range_sel
  import pll_search_pkg::*;
(
  input  logic newgen_i,
  input  logic panel_i,
  output lim_t lim_o
);

  always_comb begin
    lim_o       = '0;
    lim_o.pt_lo = 7'd5;
    lim_o.pt_hi = 7'd80;
    if (newgen_i) begin
      lim_o.m1_lo = 8'd10;  lim_o.m1_hi = 8'd20;
      lim_o.m2_lo = 8'd5;   lim_o.m2_hi = 8'd9;
      lim_o.mt_lo = 8'd70;  lim_o.mt_hi = 8'd120;
      lim_o.nt_lo = 4'd3;   lim_o.nt_hi = 4'd8;
      if (panel_i) begin
        lim_o.pt_lo = 7'd7;
        lim_o.pt_hi = 7'd98;
      end
    end else begin
      lim_o.m1_lo = 8'd16;  lim_o.m1_hi = 8'd24;
      lim_o.m2_lo = 8'd7;   lim_o.m2_hi = 8'd11;
      lim_o.mt_lo = 8'd90;  lim_o.mt_hi = 8'd130;
      lim_o.nt_lo = 4'd4;   lim_o.nt_hi = 4'd8;
      if (panel_i) begin
        lim_o.nt_lo = 4'd3;
        lim_o.mt_lo = 8'd88;
      end
    end
  end

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int NUM_W = 28,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   trial, diff;

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    trial  = {rem_q, quo_q[NUM_W-1]};
    diff   = trial - {1'b0, den_q};
    if (go_i) begin
      quo_d = num_i;
      rem_d = '0;
      den_d = den_i;
      cnt_d = CNT_W'(NUM_W);
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = diff[DEN_W-1:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = trial[DEN_W-1:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b0};
      end
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R1: partial remainder always stays below the divisor
  p_rem_below_den_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (rem_q < den_q));

  // R1: a division is never started with a zero divisor
  p_den_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (den_i != '0));

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int REF_W = 20,
  parameter int TGT_W = 20,
  parameter int FLD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic [REF_W-1:0]   refclk_i,
  input  logic               panel_i,
  input  logic               newgen_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               found_o,
  output logic [FLD_W-1:0]   m1_o,
  output logic [FLD_W-1:0]   m2_o,
  output logic [FLD_W-1:0]   n_o,
  output logic [3:0]         p1_o,
  output logic [3:0]         p2_o,
  output logic [3*FLD_W-1:0] fp_word_o,
  output logic [7:0]         p1_field_o
);

  localparam int MT_W   = 8;
  localparam int NT_W   = 4;
  localparam int PD_W   = 7;
  localparam int PROD_W = REF_W + MT_W;
  localparam int VCO_W  = 22;
  localparam int PW     = PROD_W + NT_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  st_t              st_q, st_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             pan_q, pan_d, gen_q, gen_d;
  logic [3:0]       p2_q, p2_d, p1_c, p1_d, bp1_q, bp1_d;
  logic [7:0]       m1_c, m1_d, m2_c, m2_d, bm1_q, bm1_d, bm2_q, bm2_d;
  logic [2:0]       n_c, n_d, bn_q, bn_d;
  logic [VCO_W-1:0] vco_q, vco_d, berr_q, berr_d;
  logic             found_q, found_d, done_q, done_d;

  lim_t lim_in, lim_q;
  pll_range_sel u_lim_in (.newgen_i(newgen_i), .panel_i(panel_i), .lim_o(lim_in));
  pll_range_sel u_lim_q  (.newgen_i(gen_q),    .panel_i(pan_q),   .lim_o(lim_q));

  logic [MT_W-1:0]   mtot;
  logic [NT_W-1:0]   ntot;
  logic [PD_W-1:0]   ptot, pprod;
  logic [PROD_W-1:0] prod, vquo;
  logic [VCO_W-1:0]  dquo, tgt_x, err;
  logic              vgo, vdone, dgo, ddone;
  logic              trip_ok, p_ok, vco_ok, dot_ok, trip_last;
  logic              step_p1, step_trip;

  assign mtot  = (m1_c + 8'd2) * 8'd5 + m2_c + 8'd2;
  assign ntot  = {1'b0, n_c} + 4'd2;
  assign ptot  = {3'b0, p1_c} + {3'b0, p2_q};
  assign pprod = {3'b0, p1_c} * {3'b0, p2_q};
  assign prod  = PROD_W'(ref_q) * PROD_W'(mtot);
  assign tgt_x = VCO_W'(tgt_q);
  assign err   = (dquo >= tgt_x) ? (dquo - tgt_x) : (tgt_x - dquo);

  pll_seq_div #(.NUM_W(PROD_W), .DEN_W(NT_W)) u_vdiv (
    .clk(clk), .rst_n(rst_ns), .go_i(vgo), .num_i(prod), .den_i(ntot),
    .done_o(vdone), .quo_o(vquo));

  pll_seq_div #(.NUM_W(VCO_W), .DEN_W(PD_W)) u_ddiv (
    .clk(clk), .rst_n(rst_ns), .go_i(dgo), .num_i(vco_q), .den_i(pprod),
    .done_o(ddone), .quo_o(dquo));

  assign trip_ok = (m1_c >= lim_q.m1_lo) && (m1_c <= lim_q.m1_hi) &&
                   (m2_c >= lim_q.m2_lo) && (m2_c <= lim_q.m2_hi) &&
                   (m1_c > m2_c) &&
                   (mtot >= lim_q.mt_lo) && (mtot <= lim_q.mt_hi) &&
                   (ntot >= lim_q.nt_lo) && (ntot <= lim_q.nt_hi);
  assign p_ok    = (p1_c >= 4'd1) && (p1_c <= 4'(P1_LAST)) &&
                   (ptot >= lim_q.pt_lo) && (ptot <= lim_q.pt_hi);
  assign vco_ok  = (vquo >= PROD_W'(VCO_LO)) && (vquo <= PROD_W'(VCO_HI));
  assign dot_ok  = (dquo >= VCO_W'(DOT_LO)) && (dquo <= VCO_W'(DOT_HI));
  assign trip_last = (n_c == 3'(N_LAST)) && (m2_c == lim_q.m2_hi - 8'd1) &&
                     (m1_c == lim_q.m1_hi);

  always_comb begin
    st_d = st_q;   tgt_d = tgt_q; ref_d = ref_q; pan_d = pan_q; gen_d = gen_q;
    p2_d = p2_q;   p1_d = p1_c;   m1_d = m1_c;   m2_d = m2_c;   n_d = n_c;
    vco_d = vco_q; berr_d = berr_q;
    bm1_d = bm1_q; bm2_d = bm2_q; bn_d = bn_q;   bp1_d = bp1_q;
    found_d = found_q; done_d = 1'b0;
    vgo = 1'b0; dgo = 1'b0; step_p1 = 1'b0; step_trip = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        tgt_d = target_i;  ref_d = refclk_i;
        pan_d = panel_i;   gen_d = newgen_i;
        p2_d  = pick_p2(panel_i, target_i < TGT_W'(P2_SPLIT));
        m1_d  = lim_in.m1_lo;  m2_d = lim_in.m2_lo;
        n_d   = 3'(N_FIRST);   p1_d = 4'd1;
        berr_d = VCO_W'(target_i);
        bm1_d = '0; bm2_d = '0; bn_d = '0; bp1_d = '0;
        found_d = 1'b0;
        st_d  = ST_TRIP;
      end
      ST_TRIP: begin
        if (trip_ok) begin vgo = 1'b1; st_d = ST_VDIV; end
        else step_trip = 1'b1;
      end
      ST_VDIV: if (vdone) begin
        if (vco_ok) begin
          vco_d = vquo[VCO_W-1:0];
          p1_d  = 4'd1;
          st_d  = ST_PCHK;
        end else step_trip = 1'b1;
      end
      ST_PCHK: begin
        if (p_ok) begin dgo = 1'b1; st_d = ST_DDIV; end
        else step_p1 = 1'b1;
      end
      ST_DDIV: if (ddone) begin
        if (dot_ok && (err < berr_q)) begin
          berr_d = err;
          bm1_d = m1_c; bm2_d = m2_c; bn_d = n_c; bp1_d = p1_c;
        end
        step_p1 = 1'b1;
      end
      ST_FIN: begin
        found_d = (berr_q != tgt_x);
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (step_p1) begin
      if (p1_c == 4'(P1_LAST)) step_trip = 1'b1;
      else begin p1_d = p1_c + 4'd1; st_d = ST_PCHK; end
    end
    if (step_trip) begin
      if (trip_last) st_d = ST_FIN;
      else begin
        st_d = ST_TRIP;
        if (n_c != 3'(N_LAST)) n_d = n_c + 3'd1;
        else begin
          n_d = 3'(N_FIRST);
          if (m2_c != lim_q.m2_hi - 8'd1) m2_d = m2_c + 8'd1;
          else begin m2_d = lim_q.m2_lo; m1_d = m1_c + 8'd1; end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE; tgt_q <= '0; ref_q <= '0; pan_q <= 1'b0; gen_q <= 1'b0;
      p2_q <= '0; p1_c <= '0; m1_c <= '0; m2_c <= '0; n_c <= '0;
      vco_q <= '0; berr_q <= '0;
      bm1_q <= '0; bm2_q <= '0; bn_q <= '0; bp1_q <= '0;
      found_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; tgt_q <= tgt_d; ref_q <= ref_d; pan_q <= pan_d; gen_q <= gen_d;
      p2_q <= p2_d; p1_c <= p1_d; m1_c <= m1_d; m2_c <= m2_d; n_c <= n_d;
      vco_q <= vco_d; berr_q <= berr_d;
      bm1_q <= bm1_d; bm2_q <= bm2_d; bn_q <= bn_d; bp1_q <= bp1_d;
      found_q <= found_d; done_q <= done_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign found_o    = found_q;
  assign m1_o       = FLD_W'(bm1_q);
  assign m2_o       = FLD_W'(bm2_q);
  assign n_o        = FLD_W'(bn_q);
  assign p1_o       = bp1_q;
  assign p2_o       = p2_q;
  assign fp_word_o  = {FLD_W'(bn_q), FLD_W'(bm1_q), FLD_W'(bm2_q)};
  assign p1_field_o = (bp1_q == 4'd0) ? 8'd0 : (8'd1 << (bp1_q - 4'd1));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |=> !done_o);

  // R9: results hold while idle and no new search is requested
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy_o && !start_i) |=> ($stable(fp_word_o) && $stable(found_o) &&
                               $stable(p1_field_o)));

  // R1: the VCO quotient is the floor of ref*M/(n+2)
  p_vco_quot_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_VDIV && vdone) |->
      (({NT_W'(0), vquo} * PW'(ntot) <= PW'(prod)) &&
       (PW'(prod) < ({NT_W'(0), vquo} + PW'(1)) * PW'(ntot))));

  // R7: the best error never grows during a sweep
  p_err_mono_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_o |=> (berr_q <= $past(berr_q)));

  // R2: a found result lies inside the captured generation ranges
  p_found_range_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && found_o) |->
      ((bm1_q >= lim_q.m1_lo) && (bm1_q <= lim_q.m1_hi) &&
       (bm2_q >= lim_q.m2_lo) && (bm2_q < lim_q.m2_hi) && (bm1_q > bm2_q)));

  // R8: the p1 field is one-hot whenever a result was found
  p_field_onehot_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |-> (found_o ? $onehot(p1_field_o) : (p1_field_o == 8'd0)));

  // R7: a failed search reports a zero packed word
  p_nf_zero_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && !found_o) |-> (fp_word_o == '0));

endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;

  logic        clk = 1'b0;
  logic        rst_n, start, panel, newgen;
  logic [19:0] target, refclk;
  logic        busy, done, found;
  logic [7:0]  m1, m2, n, field;
  logic [3:0]  p1, p2;
  logic [23:0] fp;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pll_div_search uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
    .refclk_i(refclk), .panel_i(panel), .newgen_i(newgen),
    .busy_o(busy), .done_o(done), .found_o(found), .m1_o(m1), .m2_o(m2),
    .n_o(n), .p1_o(p1), .p2_o(p2), .fp_word_o(fp), .p1_field_o(field));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int tgt, input int rk, input bit pan, input bit gen,
                                output int f, output int o_m1, output int o_m2,
                                output int o_n, output int o_p1, output int o_p2);
    int m1lo, m1hi, m2lo, m2hi, mlo, mhi, nlo, nhi, plo, phi;
    longint err;
    plo = 5; phi = 80;
    if (gen) begin
      m1lo = 10; m1hi = 20; m2lo = 5; m2hi = 9; mlo = 70; mhi = 120; nlo = 3; nhi = 8;
      if (pan) begin plo = 7; phi = 98; end
    end else begin
      m1lo = 16; m1hi = 24; m2lo = 7; m2hi = 11; mlo = 90; mhi = 130; nlo = 4; nhi = 8;
      if (pan) begin nlo = 3; mlo = 88; end
    end
    o_p2 = pan ? ((tgt < 200000) ? 14 : 7) : ((tgt < 200000) ? 10 : 5);
    err = tgt; o_m1 = 0; o_m2 = 0; o_n = 0; o_p1 = 0;
    for (int a = m1lo; a <= m1hi; a++)
      for (int b = m2lo; b < m2hi; b++)
        for (int c = 1; c <= 6; c++)
          for (int d = 1; d <= 8; d++) begin
            int mm;
            longint vco, dot, e;
            mm = 5 * (a + 2) + (b + 2);
            if (d + o_p2 < plo || d + o_p2 > phi || a <= b) continue;
            if (mm < mlo || mm > mhi || c + 2 < nlo || c + 2 > nhi) continue;
            vco = longint'(rk) * mm / (c + 2);
            if (vco < 1400000 || vco > 2800000) continue;
            dot = vco / (d * o_p2);
            if (dot < 20000 || dot > 400000) continue;
            e = (dot > tgt) ? dot - tgt : tgt - dot;
            if (e < err) begin
              err = e; o_m1 = a; o_m2 = b; o_n = c; o_p1 = d;
            end
          end
    f = (err != tgt) ? 1 : 0;
  endfunction

  task automatic t_reset();
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(done == 1'b0, "R9 done after reset", done, 0);
    chk(found == 1'b0, "R7 found after reset", found, 0);
    chk(fp == 24'd0, "R8 packed word after reset", fp, 0);
  endtask

  task automatic run_case(input string nm, input int tgt, input int rk, input bit pan,
                          input bit gen, input bit poke);
    int f, em1, em2, en, ep1, ep2, mm;
    longint vco, dot;
    logic [23:0] fp_hold;
    model(tgt, rk, pan, gen, f, em1, em2, en, ep1, ep2);
    @(negedge clk);
    target = 20'(tgt); refclk = 20'(rk); panel = pan; newgen = gen; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R9 busy after start ", nm}, busy, 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      target = 20'(tgt + 12345); panel = ~pan; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(busy == 1'b0, {"R9 busy low at done ", nm}, busy, 0);
    chk(found == f[0], {"R7 found ", nm}, found, f);
    chk(p2 == 4'(ep2), {"R5 p2 ", nm}, p2, ep2);
    chk(m1 == 8'(em1), {"R6 m1 ", nm}, m1, em1);
    chk(m2 == 8'(em2), {"R6 m2 ", nm}, m2, em2);
    chk(n == 8'(en), {"R6 n ", nm}, n, en);
    chk(p1 == 4'(ep1), {"R6 p1 ", nm}, p1, ep1);
    if (f != 0) begin
      chk(fp == 24'((en << 16) | (em1 << 8) | em2), {"R8 packed word ", nm}, fp,
          (en << 16) | (em1 << 8) | em2);
      chk(field == 8'(1 << (ep1 - 1)), {"R8 p1 one-hot ", nm}, field, 1 << (ep1 - 1));
      mm  = 5 * (m1 + 2) + (m2 + 2);
      vco = longint'(rk) * mm / (n + 2);
      dot = vco / (p1 * p2);
      chk(vco >= 1400000 && vco <= 2800000, {"R4 vco window ", nm}, vco, 1400000);
      chk(dot >= 20000 && dot <= 400000, {"R4 output window ", nm}, dot, 20000);
      chk(m1 > m2, {"R4 m1 above m2 ", nm}, m1, m2);
      chk((p1 + p2 >= (gen && pan ? 7 : 5)) && (p1 + p2 <= (gen && pan ? 98 : 80)),
          {"R3 post-divide sum ", nm}, p1 + p2, 5);
      chk(gen ? (m1 >= 10 && m1 <= 20 && mm >= 70 && mm <= 120)
              : (m1 >= 16 && m1 <= 24 && mm >= (pan ? 88 : 90) && mm <= 130),
          {"R2 generation ranges ", nm}, m1, em1);
      chk((dot > tgt ? dot - tgt : tgt - dot) < tgt, {"R1 error below target ", nm}, dot, tgt);
    end else begin
      chk(fp == 24'd0, {"R7 packed word zero ", nm}, fp, 0);
      chk(field == 8'd0, {"R7 p1 field zero ", nm}, field, 0);
    end
    fp_hold = fp;
    @(negedge clk);
    chk(done == 1'b0, {"R9 done single pulse ", nm}, done, 0);
    target = 20'(tgt + 777); panel = ~pan; newgen = ~gen;
    repeat (5) @(negedge clk);
    chk(fp == fp_hold, {"R9 idle hold ", nm}, fp, fp_hold);
    chk(busy == 1'b0, {"R9 stays idle ", nm}, busy, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual no finish expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; panel = 1'b0; newgen = 1'b0;
    target = '0; refclk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_case("newgen crt low", 108000, 96000, 1'b0, 1'b1, 1'b1);
    run_case("oldgen panel low", 65000, 96000, 1'b1, 1'b0, 1'b0);
    run_case("newgen panel high", 250000, 96000, 1'b1, 1'b1, 1'b0);
    run_case("no legal vco", 300000, 1000, 1'b0, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule